// File: doc/BRIEF.md
# Watchdog and Sleep-Key Controller

This block guards a small processor core against runaway firmware and against an accidental entry into power-down. It holds a watchdog counter that stays off after reset until software issues its first clear-watchdog instruction. From then on, each clear zeroes the counter. If a full timeout window passes with no clear, the block raises a chip-reset request.

The block also screens the sleep instruction. The core may stop its clock only if software has first written a one-byte key (A5h) into a small key register. A sleep with any other key value becomes a reset request. While the core is stopped, the watchdog is frozen. Only an enabled external wake line can bring the core back. A wake starts a stabilization count, and the clock stays gated until that count completes.

Top module: `wsg_top`

## Requirements
- R1: After reset, `rst_req_o`, `clk_stop_o` and `wake_o` are low, the key register holds 00h and the watchdog is disarmed. A disarmed watchdog never requests a reset, however long it is left alone.
- R2: A clear-watchdog strobe sampled while the core runs zeroes the counter and arms the watchdog.
- R3: Once armed, if 2^WDT_W clock edges follow the edge that took the last clear with no further clear, `rst_req_o` goes high for one cycle. The same edge disarms the watchdog and zeroes the key.
- R4: While `clk_stop_o` is high, the watchdog count is frozen, and it never requests a reset. After the core wakes, counting resumes from the held value.
- R5: A sleep strobe taken while the key register holds A5h sets `clk_stop_o` on the next edge, with no reset request.
- R6: A sleep strobe taken while the key register holds any value other than A5h raises `rst_req_o` for one cycle and does not stop the clock.
- R7: The key register is cleared to 00h on every successful power-down entry and on every reset request. A second sleep without re-writing A5h therefore raises a reset request.
- R8: While stopped, the block leaves power-down only when some bit of `ext_wake_i & wake_en_i` is 1. A wake line whose enable bit is 0 has no effect.
- R9: On an accepted wake, `wake_o` pulses for one cycle. `clk_stop_o` stays high for 2^STAB_W edges counted from the wake edge, and then falls.
- R10: While `clk_stop_o` is high, the clear-watchdog strobe, the sleep strobe and key writes have no effect.
- R11: A clear strobe on the same edge as the watchdog expiry wins: no reset request is raised, and the count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clrwdt_i | input | 1 | Clear-watchdog instruction strobe |
| sleep_i | input | 1 | Sleep instruction strobe |
| key_we_i | input | 1 | Key register write enable |
| key_wdata_i | input | 8 | Key register write data |
| ext_wake_i | input | 2 | External interrupt wake requests 0 and 1 |
| wake_en_i | input | 2 | Per-line enables for the wake requests |
| rst_req_o | output | 1 | One-cycle chip-reset request |
| clk_stop_o | output | 1 | Core clock gated (power-down or stabilization) |
| wake_o | output | 1 | One-cycle pulse when an accepted wake starts stabilization |

## Verification
The hardest situation to reach is a watchdog that is part way through its window when the core enters power-down. The frozen count must then carry across the stop and the stabilization phase, so that expiry lands late by exactly the stopped time. The stimulus arms the watchdog and lets it run for a while. It then writes the key, sleeps, waits a long stop with disabled and enabled wake lines, and lets the counter expire after release. The cycle-level model predicts the expiry edge, and that edge is compared against the design. A clear landing exactly on the expiry edge is reached by pulsing a clear, then idling exactly one window less one cycle before the next clear.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
  typedef enum logic [1:0] {
    PM_RUN    = 2'd0,
    PM_HALT   = 2'd1,
    PM_SETTLE = 2'd2
  } pm_state_t;

  localparam logic [7:0] SLEEP_KEY = 8'hA5;

  // true when the key register holds the sleep-permit byte
  function automatic logic key_matches(input logic [7:0] k);
    return k == SLEEP_KEY;
  endfunction

  // true when a counter of width w sits at its final value 2^w-1
  function automatic logic at_last(input logic [31:0] v, input int w);
    return v == ((32'd1 << w) - 32'd1);
  endfunction
endpackage

// File: rtl/wsg_wdt.sv
module wsg_wdt #(
  parameter int WDT_W = 21
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  input  logic kill,
  output logic armed,
  output logic expire
);
  logic [WDT_W-1:0] cnt;

  assign expire = armed & run & ~clr & wsg_pkg::at_last(32'(cnt), WDT_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (kill) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (run) begin
      if (clr) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (armed) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_ARM_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(clr)); // R2
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    (run && clr && !kill) |=> (cnt == '0 && armed)); // R2
  AST_FROZEN_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run) |=> ($stable(cnt) && $stable(armed))); // R4
  AST_NO_EXPIRE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run) |-> !expire); // R4
endmodule

// File: rtl/wsg_key.sv
module wsg_key (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  input  logic       wipe,
  output logic [7:0] key,
  output logic       key_ok
);
  assign key_ok = wsg_pkg::key_matches(key);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    key <= 8'h00;
    else if (wipe) key <= 8'h00;
    else if (we)   key <= wdata;
  end

  AST_KEY_WIPED: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (key == 8'h00)); // R7
endmodule

// File: rtl/wsg_pwr.sv
module wsg_pwr #(
  parameter int STAB_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enter,
  input  logic wake_hit,
  output logic clk_stop,
  output logic wake_pulse
);
  import wsg_pkg::*;

  pm_state_t          state;
  logic [STAB_W-1:0]  scnt;

  assign clk_stop = (state != PM_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= PM_RUN;
      scnt       <= '0;
      wake_pulse <= 1'b0;
    end else begin
      wake_pulse <= 1'b0;
      case (state)
        PM_RUN: if (enter) state <= PM_HALT;
        PM_HALT: if (wake_hit) begin
          state      <= PM_SETTLE;
          scnt       <= '0;
          wake_pulse <= 1'b1;
        end
        PM_SETTLE: begin
          if (at_last(32'(scnt), STAB_W)) state <= PM_RUN;
          else                            scnt  <= scnt + 1'b1;
        end
        default: state <= PM_RUN;
      endcase
    end
  end

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_HALT && !wake_hit) |=> (state == PM_HALT)); // R8
  AST_WAKE_STARTS_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_HALT && wake_hit) |=> (wake_pulse && state == PM_SETTLE && scnt == '0)); // R9
  AST_RELEASE_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_stop) |-> $past(state == PM_SETTLE)); // R9
  AST_WAKE_WHILE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> clk_stop); // R9
endmodule

// File: rtl/wsg_top.sv
module wsg_top #(
  parameter int WDT_W  = 21,
  parameter int STAB_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clrwdt_i,
  input  logic       sleep_i,
  input  logic       key_we_i,
  input  logic [7:0] key_wdata_i,
  input  logic [1:0] ext_wake_i,
  input  logic [1:0] wake_en_i,
  output logic       rst_req_o,
  output logic       clk_stop_o,
  output logic       wake_o
);
  // named internal events
  logic       run, clr_go, sleep_go, key_ok, wdt_armed, wdt_expire;
  logic       bad_sleep, enter_go, req_now, wake_hit;
  logic [7:0] key_val;

  assign run       = ~clk_stop_o;
  assign clr_go    = clrwdt_i & run;
  assign sleep_go  = sleep_i & run;
  assign bad_sleep = sleep_go & ~key_ok;
  assign req_now   = wdt_expire | bad_sleep;
  assign enter_go  = sleep_go & key_ok & ~wdt_expire;
  assign wake_hit  = |(ext_wake_i & wake_en_i);

  wsg_wdt #(.WDT_W(WDT_W)) wdt_i (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(clr_go), .kill(req_now),
    .armed(wdt_armed), .expire(wdt_expire)
  );

  wsg_key key_i (
    .clk(clk), .rst_n(rst_n), .we(key_we_i & run), .wdata(key_wdata_i),
    .wipe(req_now | enter_go), .key(key_val), .key_ok(key_ok)
  );

  wsg_pwr #(.STAB_W(STAB_W)) pwr_i (
    .clk(clk), .rst_n(rst_n), .enter(enter_go), .wake_hit(wake_hit),
    .clk_stop(clk_stop_o), .wake_pulse(wake_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req_o <= 1'b0;
    else        rst_req_o <= req_now;
  end

  AST_GOOD_SLEEP_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_i && !clk_stop_o && key_val == 8'hA5 && !wdt_expire) |=> (clk_stop_o && !rst_req_o && key_val == 8'h00)); // R5
  AST_BAD_SLEEP_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_i && !clk_stop_o && key_val != 8'hA5) |=> (rst_req_o && !clk_stop_o)); // R6
  AST_GATED_NO_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stop_o |=> !rst_req_o); // R10
  AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdt_armed && !sleep_i) |=> !rst_req_o); // R1
  AST_GATED_KEY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_stop_o && $past(clk_stop_o)) |-> $stable(key_val)); // R10
endmodule

// File: tb/wsg_top_tb_top.sv
module wsg_top_tb_top;
  localparam int WDT_W  = 6;
  localparam int STAB_W = 4;
  localparam int TMAX   = 1 << WDT_W;
  localparam int SMAX   = 1 << STAB_W;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clrwdt_i = 1'b0, sleep_i = 1'b0, key_we_i = 1'b0;
  logic [7:0] key_wdata_i = 8'h00;
  logic [1:0] ext_wake_i = 2'b00, wake_en_i = 2'b00;
  logic       rst_req_o, clk_stop_o, wake_o;

  int vectors = 0, miscompares = 0, cycles = 0;
  string tag = "R1";
  bit done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  wsg_top #(.WDT_W(WDT_W), .STAB_W(STAB_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .clrwdt_i(clrwdt_i), .sleep_i(sleep_i),
    .key_we_i(key_we_i), .key_wdata_i(key_wdata_i), .ext_wake_i(ext_wake_i),
    .wake_en_i(wake_en_i), .rst_req_o(rst_req_o), .clk_stop_o(clk_stop_o),
    .wake_o(wake_o)
  );

  // behavioural reference: mode 0 running, 1 stopped, 2 settling
  int m_mode = 0, m_cnt = 0, m_scnt = 0, m_key = 0;
  bit m_armed = 0, m_req = 0, m_wake = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_scnt = 0; m_key = 0;
      m_armed = 0; m_req = 0; m_wake = 0;
    end else begin
      bit nreq, nwake, expd, bad, good;
      nreq = 0; nwake = 0;
      if (m_mode == 0) begin
        expd = m_armed && (m_cnt == TMAX - 1) && !clrwdt_i;
        bad  = sleep_i && (m_key != 'hA5);
        good = sleep_i && (m_key == 'hA5) && !expd;
        if (expd || bad) begin
          m_armed = 0; m_cnt = 0; m_key = 0; nreq = 1;
        end else begin
          if (clrwdt_i) begin m_armed = 1; m_cnt = 0; end
          else if (m_armed) m_cnt++;
          if (good) begin m_mode = 1; m_key = 0; end
          else if (key_we_i) m_key = key_wdata_i;
        end
      end else if (m_mode == 1) begin
        if ((ext_wake_i & wake_en_i) != 2'b00) begin
          m_mode = 2; m_scnt = 0; nwake = 1;
        end
      end else begin
        if (m_scnt == SMAX - 1) m_mode = 0;
        else m_scnt++;
      end
      m_req = nreq; m_wake = nwake;
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (rst_req_o !== m_req || clk_stop_o !== (m_mode != 0) || wake_o !== m_wake) begin
        miscompares++;
        $display("FAIL %s t=%0t actual req=%b stop=%b wake=%b expected req=%b stop=%b wake=%b",
                 tag, $time, rst_req_o, clk_stop_o, wake_o, m_req, (m_mode != 0), m_wake);
      end
    end
  end

  // watchdog for the bench run
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      miscompares++;
      $display("FAIL watchdog expired, actual cycles=%0d expected below 150000", cycles);
      finish_run();
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr();
    clrwdt_i = 1'b1; @(negedge clk); clrwdt_i = 1'b0;
  endtask

  task automatic pulse_sleep();
    sleep_i = 1'b1; @(negedge clk); sleep_i = 1'b0;
  endtask

  task automatic write_key(input logic [7:0] v);
    key_we_i = 1'b1; key_wdata_i = v; @(negedge clk); key_we_i = 1'b0;
  endtask

  task automatic explicit_check(input string r, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s explicit actual=%b expected=%b", r, act, exp);
    end
  endtask

  initial begin
    tag = "R1";
    idle(3);
    explicit_check("R1", rst_req_o | clk_stop_o | wake_o, 1'b0);
    rst_n = 1'b1;
    idle(3 * TMAX);                        // disarmed: no request ever
    explicit_check("R1", rst_req_o, 1'b0);

    tag = "R2";
    pulse_clr();
    for (int i = 0; i < 4; i++) begin idle(TMAX - 3); pulse_clr(); end
    tag = "R11";
    idle(TMAX - 1); pulse_clr();           // clear lands on the expiry edge
    idle(TMAX - 1); pulse_clr();
    tag = "R3";
    idle(TMAX + 4);                        // let it expire
    explicit_check("R3", rst_req_o, 1'b0);
    idle(2 * TMAX);                        // disarmed again after request

    tag = "R6";
    pulse_sleep(); idle(3);
    write_key(8'h5A); pulse_sleep(); idle(3);

    tag = "R5";
    write_key(8'hA5); pulse_sleep();
    explicit_check("R5", clk_stop_o, 1'b1);
    tag = "R10";
    pulse_clr(); pulse_sleep(); write_key(8'hA5); idle(5);
    tag = "R8";
    ext_wake_i = 2'b11; wake_en_i = 2'b00; idle(6);
    ext_wake_i = 2'b01; wake_en_i = 2'b10; idle(6);
    explicit_check("R8", clk_stop_o, 1'b1);
    tag = "R9";
    wake_en_i = 2'b01; @(negedge clk); ext_wake_i = 2'b00;
    idle(SMAX + 4);
    explicit_check("R9", clk_stop_o, 1'b0);
    tag = "R7";
    pulse_sleep(); idle(3);                // key was consumed: reset request

    tag = "R4";
    pulse_clr(); idle(TMAX / 2);
    write_key(8'hA5); pulse_sleep(); idle(3 * TMAX);
    ext_wake_i = 2'b10; wake_en_i = 2'b10; @(negedge clk); ext_wake_i = 2'b00;
    idle(SMAX + TMAX);
    explicit_check("R4", clk_stop_o, 1'b0);

    tag = "R1";
    rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(2 * TMAX);
    pulse_sleep(); idle(3);                // key cleared by reset
    finish_run();
  end
endmodule